// File: doc/BRIEF.md
# Partitioned Metadata Adder

This block is a single integer adder that serves scalar operands and vector operands of any element width. Each operand carries a width code and a shape flag (scalar or vector). The width code decides where the byte-level carry chain is cut, so one chain of byte adders becomes many independent lanes. Every operation also selects what happens on overflow: wrap, turn the lane into an overflow marker, clamp, or produce a double-width result. The opcode chooses between addition, subtraction and an addition that also reports the carry out of each lane.

Each operand byte has a not-a-result flag. A lane whose flags show an invalid value passes that marker to its result instead of a sum. A marker whose kind byte is zero is the "None" value, and None wins over every other marker kind. Operands that disagree in shape or width, requests the datapath cannot encode, and a widening request at the largest width do not produce data. They assert a fault flag. Results appear one clock after the request.

Top module: `part_meta_adder`

## Requirements
- R1: Results are registered: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low after any other cycle. Reset (active low, synchronous) clears `out_valid`, `fault` and `r1_valid`.
- R2: Width code w (0..3) sets elements of 2^w bytes. With `*_vec`=1 every element is an independent lane and no carry crosses a lane boundary. With `*_vec`=0 only the low element is computed, and all result bytes above it are zero with their flags clear.
- R3: Opcode 1 computes a minus b in every lane. Opcode 0 computes a plus b.
- R4: Policy 0 (wrap) returns the lane result truncated to the element width.
- R5: Policy 2 (saturate) clamps an overflowing lane. When `is_signed`=1 the limits are the signed maximum and minimum, chosen by the sign of a. When `is_signed`=0 an add clamps to all ones and a subtract clamps to zero.
- R6: Policy 1 (exception) turns an overflowing lane into a marker. All flag bits of the lane are set, its low byte holds kind 0x0F, the other bytes are zero, and `fault` stays low.
- R7: Policy 3 (widen) returns elements of 2^(w+1) bytes, sign-extended or zero-extended according to `is_signed`. A scalar gives one result with width w+1. A vector places the widened low half of the lanes in result 0 and the widened upper half in result 1, and sets `r1_valid`.
- R8: Opcode 2 (add with carry) returns the wrapped sum in result 0 and each lane's carry out as the value 0 or 1 in result 1, with the same width and shape. The policy input has no effect on this opcode.
- R9: A lane is a marker if any flag bit inside the lane is set, and its kind is the lane's low data byte. Kind 0x00 is None. If either lane is None the result lane is None. Otherwise the result takes the kind of a if a is a marker, or else the kind of b. A marker result lane has all its flag bits set, its low byte equal to the kind, and its other bytes zero. Under widen, the marker covers the whole widened lane.
- R10: `fault` is raised, with all results zero, all flags clear and `r1_valid` low, in any of these cases: the two widths differ, the two shapes differ, opcode 3 is requested, or a widen is requested at width code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 2 | 0 add, 1 subtract, 2 add with carry out |
| policy | input | 2 | 0 wrap, 1 exception marker, 2 saturate, 3 widen |
| is_signed | input | 1 | Signed interpretation for overflow, clamping and extension |
| a_width | input | 2 | Element width code of operand a |
| a_vec | input | 1 | Operand a is a vector |
| a_data | input | 64 | Operand a bytes |
| a_nar | input | 8 | Per-byte invalid flags of a |
| b_width | input | 2 | Element width code of operand b |
| b_vec | input | 1 | Operand b is a vector |
| b_data | input | 64 | Operand b bytes |
| b_nar | input | 8 | Per-byte invalid flags of b |
| out_valid | output | 1 | Result registers hold a new result |
| fault | output | 1 | Request rejected |
| r0_data | output | 64 | First result bytes |
| r0_nar | output | 8 | First result flags |
| r0_width | output | 2 | First result width code |
| r0_vec | output | 1 | First result shape |
| r1_valid | output | 1 | Second result present |
| r1_data | output | 64 | Second result bytes |
| r1_nar | output | 8 | Second result flags |
| r1_width | output | 2 | Second result width code |
| r1_vec | output | 1 | Second result shape |

## Verification
The hardest situation to reach is a single vector in which None, ordinary markers from both operands, and valid lanes sit side by side, because the priority order only shows when these cases are mixed. The stimulus builds such vectors byte by byte, placing a marker flag on an upper byte of a multi-byte lane so that detecting a marker from any byte and taking its kind from the low byte are both exercised. Signed widening of a vector is reached with lane values chosen at the signed limits, so the extension bits must come from the true sign and not from the truncated sum.

// File: rtl/pam_pkg.sv
// Shared encodings for the partitioned metadata adder.
// Assumes two-bit opcode and policy fields; kind byte 0x00 marks None.
package pam_pkg;
    localparam logic [1:0] OP_ADD  = 2'd0;
    localparam logic [1:0] OP_SUB  = 2'd1;
    localparam logic [1:0] OP_ADDC = 2'd2;

    localparam logic [1:0] POL_WRAP   = 2'd0;
    localparam logic [1:0] POL_EXCEPT = 2'd1;
    localparam logic [1:0] POL_SAT    = 2'd2;
    localparam logic [1:0] POL_WIDEN  = 2'd3;

    localparam logic [7:0] KIND_NONE = 8'h00;
    localparam logic [7:0] KIND_OVF  = 8'h0F;
endpackage

// File: rtl/pam_decode.sv
// Request decoder: validates operand metadata and derives lane masks.
// Assumes width code w means 2^w-byte elements; a scalar uses only the low element.
module pam_decode
    import pam_pkg::*;
#(
    parameter int NB   = 8,
    parameter int WC_W = 2
) (
    input  logic [1:0]      op_code,
    input  logic [1:0]      policy,
    input  logic [WC_W-1:0] a_width,
    input  logic            a_vec,
    input  logic [WC_W-1:0] b_width,
    input  logic            b_vec,
    output logic            bad_req,
    output logic            is_sub,
    output logic            carry_op,
    output logic            widen_op,
    output logic [NB-1:0]   lane_start,
    output logic [NB-1:0]   lane_ok
);
    localparam int MAXW = $clog2(NB);

    // Opcode class decode.
    always_comb begin
        is_sub   = (op_code == OP_SUB);
        carry_op = (op_code == OP_ADDC);
        widen_op = (policy == POL_WIDEN) && (op_code != OP_ADDC);
    end

    // Rejection of mismatched or unencodable requests.
    always_comb begin
        bad_req = (a_width != b_width) || (a_vec != b_vec) ||
                  (int'(a_width) > MAXW) || (op_code == 2'd3) ||
                  (widen_op && (int'(a_width) == MAXW));
    end

    // Per-byte lane boundary and activity masks.
    always_comb begin
        int eb;
        eb = 1 << a_width;
        for (int i = 0; i < NB; i++) begin
            lane_start[i] = ((i & (eb - 1)) == 0);
            lane_ok[i]    = a_vec || (i < eb);
        end
    end
endmodule

// File: rtl/pam_carry_chain.sv
// Byte-sliced adder whose carry chain is cut at every lane start.
// Assumes subtraction as a + ~b + 1 with the +1 injected at each lane start.
module pam_carry_chain #(
    parameter int NB = 8
) (
    input  logic [8*NB-1:0] a_data,
    input  logic [8*NB-1:0] b_data,
    input  logic            is_sub,
    input  logic [NB-1:0]   lane_start,
    output logic [8*NB-1:0] sum,
    output logic [NB-1:0]   cout
);
    logic [NB-1:0] cin;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [7:0] bx;
        // Operand b inversion for subtraction.
        assign bx = is_sub ? ~b_data[8*g +: 8] : b_data[8*g +: 8];
        if (g == 0) begin : g_first
            // First byte always starts a lane.
            assign cin[g] = is_sub;
        end else begin : g_rest
            // Carry either restarts at a lane boundary or ripples in.
            assign cin[g] = lane_start[g] ? is_sub : cout[g-1];
        end
        // Nine-bit byte add producing sum byte and carry out.
        assign {cout[g], sum[8*g +: 8]} = {1'b0, a_data[8*g +: 8]} + {1'b0, bx} + {8'd0, cin[g]};
    end
endmodule

// File: rtl/pam_lane_fix.sv
// Per-lane result shaping: marker propagation, overflow policy,
// widening extension bytes and carry-result bytes.
// Assumes each byte evaluates the full lane it belongs to.
module pam_lane_fix
    import pam_pkg::*;
#(
    parameter int NB   = 8,
    parameter int WC_W = 2
) (
    input  logic [WC_W-1:0] width,
    input  logic [1:0]      policy,
    input  logic            is_signed,
    input  logic            is_sub,
    input  logic            carry_op,
    input  logic [NB-1:0]   lane_ok,
    input  logic [8*NB-1:0] a_data,
    input  logic [NB-1:0]   a_nar,
    input  logic [8*NB-1:0] b_data,
    input  logic [NB-1:0]   b_nar,
    input  logic [8*NB-1:0] sum,
    input  logic [NB-1:0]   cout,
    output logic [8*NB-1:0] p_data,
    output logic [NB-1:0]   p_nar,
    output logic [8*NB-1:0] x_data,
    output logic [NB-1:0]   x_nar,
    output logic [8*NB-1:0] c_data,
    output logic [NB-1:0]   c_nar
);
    // Byte-by-byte evaluation of the owning lane.
    always_comb begin
        int eb, base, top;
        logic ma, mb, is_none, meta, sa, sb, ss, co, ovf;
        logic [7:0] ka, kb, kind, satb, extb, lowb;
        eb = 1 << width;
        for (int i = 0; i < NB; i++) begin
            base = i & ~(eb - 1);
            top  = base + eb - 1;
            ma = 1'b0;
            mb = 1'b0;
            for (int j = 0; j < NB; j++) begin
                if ((j & ~(eb - 1)) == base) begin
                    ma = ma | a_nar[j];
                    mb = mb | b_nar[j];
                end
            end
            ka      = a_data[8*base +: 8];
            kb      = b_data[8*base +: 8];
            is_none = (ma && (ka == KIND_NONE)) || (mb && (kb == KIND_NONE));
            meta    = ma | mb;
            kind    = is_none ? KIND_NONE : (ma ? ka : kb);
            sa  = a_data[8*top + 7];
            sb  = b_data[8*top + 7] ^ is_sub;
            ss  = sum[8*top + 7];
            co  = cout[top];
            ovf = is_signed ? ((sa == sb) && (ss != sa)) : (is_sub ? !co : co);
            lowb = (i == base) ? kind : 8'h00;

            if (is_signed) begin
                if (i == top) satb = sa ? 8'h80 : 8'h7F;
                else          satb = sa ? 8'h00 : 8'hFF;
                extb = {8{ovf ? sa : ss}};
            end else begin
                satb = is_sub ? 8'h00 : 8'hFF;
                if (is_sub)         extb = co ? 8'h00 : 8'hFF;
                else if (i == base) extb = {7'd0, co};
                else                extb = 8'h00;
            end

            if (!lane_ok[i]) begin
                p_data[8*i +: 8] = 8'h00;
                p_nar[i]         = 1'b0;
            end else if (meta) begin
                p_data[8*i +: 8] = lowb;
                p_nar[i]         = 1'b1;
            end else if (!carry_op && ovf && (policy == POL_EXCEPT)) begin
                p_data[8*i +: 8] = (i == base) ? KIND_OVF : 8'h00;
                p_nar[i]         = 1'b1;
            end else if (!carry_op && ovf && (policy == POL_SAT)) begin
                p_data[8*i +: 8] = satb;
                p_nar[i]         = 1'b0;
            end else begin
                p_data[8*i +: 8] = sum[8*i +: 8];
                p_nar[i]         = 1'b0;
            end

            if (!lane_ok[i]) begin
                x_data[8*i +: 8] = 8'h00;
                x_nar[i]         = 1'b0;
                c_data[8*i +: 8] = 8'h00;
                c_nar[i]         = 1'b0;
            end else if (meta) begin
                x_data[8*i +: 8] = 8'h00;
                x_nar[i]         = 1'b1;
                c_data[8*i +: 8] = lowb;
                c_nar[i]         = 1'b1;
            end else begin
                x_data[8*i +: 8] = extb;
                x_nar[i]         = 1'b0;
                c_data[8*i +: 8] = (i == base) ? {7'd0, co} : 8'h00;
                c_nar[i]         = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pam_pack.sv
// Result packer: selects single, carry-pair or widened-pair layouts and
// zeroes everything on a rejected request.
// Assumes widened lane k occupies bytes [2eb*k, 2eb*k+2eb) of {r1, r0}.
module pam_pack #(
    parameter int NB   = 8,
    parameter int WC_W = 2
) (
    input  logic            bad_req,
    input  logic            widen_op,
    input  logic            carry_op,
    input  logic [WC_W-1:0] width,
    input  logic            vec,
    input  logic [8*NB-1:0] p_data,
    input  logic [NB-1:0]   p_nar,
    input  logic [8*NB-1:0] x_data,
    input  logic [NB-1:0]   x_nar,
    input  logic [8*NB-1:0] c_data,
    input  logic [NB-1:0]   c_nar,
    output logic [8*NB-1:0] r0_data,
    output logic [NB-1:0]   r0_nar,
    output logic [WC_W-1:0] r0_width,
    output logic [8*NB-1:0] r1_data,
    output logic [NB-1:0]   r1_nar,
    output logic            r1_valid
);
    logic [16*NB-1:0] wide_d;
    logic [2*NB-1:0]  wide_n;

    // Interleave low-half and extension bytes into double-width lanes.
    always_comb begin
        int eb, k, j, src;
        eb = 1 << width;
        for (int o = 0; o < 2*NB; o++) begin
            k = o / (2*eb);
            j = o % (2*eb);
            if (j < eb) begin
                src = eb*k + j;
                if (src < NB) begin
                    wide_d[8*o +: 8] = p_data[8*src +: 8];
                    wide_n[o]        = p_nar[src];
                end else begin
                    wide_d[8*o +: 8] = 8'h00;
                    wide_n[o]        = 1'b0;
                end
            end else begin
                src = eb*k + j - eb;
                if (src < NB) begin
                    wide_d[8*o +: 8] = x_data[8*src +: 8];
                    wide_n[o]        = x_nar[src];
                end else begin
                    wide_d[8*o +: 8] = 8'h00;
                    wide_n[o]        = 1'b0;
                end
            end
        end
    end

    // Final layout selection.
    always_comb begin
        r0_width = width;
        if (bad_req) begin
            r0_data  = '0;
            r0_nar   = '0;
            r1_data  = '0;
            r1_nar   = '0;
            r1_valid = 1'b0;
        end else if (widen_op) begin
            r0_data  = wide_d[8*NB-1:0];
            r0_nar   = wide_n[NB-1:0];
            r1_data  = vec ? wide_d[16*NB-1:8*NB] : '0;
            r1_nar   = vec ? wide_n[2*NB-1:NB] : '0;
            r1_valid = vec;
            r0_width = width + 1'b1;
        end else if (carry_op) begin
            r0_data  = p_data;
            r0_nar   = p_nar;
            r1_data  = c_data;
            r1_nar   = c_nar;
            r1_valid = 1'b1;
        end else begin
            r0_data  = p_data;
            r0_nar   = p_nar;
            r1_data  = '0;
            r1_nar   = '0;
            r1_valid = 1'b0;
        end
    end
endmodule

// File: rtl/part_meta_adder.sv
// Partitioned adder with per-byte invalid-value metadata and a per-operation
// overflow policy. One registered stage; combinational datapath feeds it.
// Assumes operands of a valid request share width and shape.
module part_meta_adder #(
    parameter int NB   = 8,
    parameter int WC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op_code,
    input  logic [1:0]      policy,
    input  logic            is_signed,
    input  logic [WC_W-1:0] a_width,
    input  logic            a_vec,
    input  logic [8*NB-1:0] a_data,
    input  logic [NB-1:0]   a_nar,
    input  logic [WC_W-1:0] b_width,
    input  logic            b_vec,
    input  logic [8*NB-1:0] b_data,
    input  logic [NB-1:0]   b_nar,
    output logic            out_valid,
    output logic            fault,
    output logic [8*NB-1:0] r0_data,
    output logic [NB-1:0]   r0_nar,
    output logic [WC_W-1:0] r0_width,
    output logic            r0_vec,
    output logic            r1_valid,
    output logic [8*NB-1:0] r1_data,
    output logic [NB-1:0]   r1_nar,
    output logic [WC_W-1:0] r1_width,
    output logic            r1_vec
);
    logic            bad_req, is_sub, carry_op, widen_op;
    logic [NB-1:0]   lane_start, lane_ok, cout;
    logic [8*NB-1:0] sum, p_data, x_data, c_data, n0_data, n1_data;
    logic [NB-1:0]   p_nar, x_nar, c_nar, n0_nar, n1_nar;
    logic [WC_W-1:0] n0_width;
    logic            n1_valid;

    pam_decode #(.NB(NB), .WC_W(WC_W)) decode_i (
        .op_code(op_code), .policy(policy),
        .a_width(a_width), .a_vec(a_vec), .b_width(b_width), .b_vec(b_vec),
        .bad_req(bad_req), .is_sub(is_sub), .carry_op(carry_op), .widen_op(widen_op),
        .lane_start(lane_start), .lane_ok(lane_ok)
    );

    pam_carry_chain #(.NB(NB)) chain_i (
        .a_data(a_data), .b_data(b_data), .is_sub(is_sub),
        .lane_start(lane_start), .sum(sum), .cout(cout)
    );

    pam_lane_fix #(.NB(NB), .WC_W(WC_W)) fix_i (
        .width(a_width), .policy(policy), .is_signed(is_signed), .is_sub(is_sub),
        .carry_op(carry_op), .lane_ok(lane_ok),
        .a_data(a_data), .a_nar(a_nar), .b_data(b_data), .b_nar(b_nar),
        .sum(sum), .cout(cout),
        .p_data(p_data), .p_nar(p_nar), .x_data(x_data), .x_nar(x_nar),
        .c_data(c_data), .c_nar(c_nar)
    );

    pam_pack #(.NB(NB), .WC_W(WC_W)) pack_i (
        .bad_req(bad_req), .widen_op(widen_op), .carry_op(carry_op),
        .width(a_width), .vec(a_vec),
        .p_data(p_data), .p_nar(p_nar), .x_data(x_data), .x_nar(x_nar),
        .c_data(c_data), .c_nar(c_nar),
        .r0_data(n0_data), .r0_nar(n0_nar), .r0_width(n0_width),
        .r1_data(n1_data), .r1_nar(n1_nar), .r1_valid(n1_valid)
    );

    // Output register stage; captures a result only for a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            fault     <= 1'b0;
            r0_data   <= '0;
            r0_nar    <= '0;
            r0_width  <= '0;
            r0_vec    <= 1'b0;
            r1_valid  <= 1'b0;
            r1_data   <= '0;
            r1_nar    <= '0;
            r1_width  <= '0;
            r1_vec    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fault    <= bad_req;
                r0_data  <= n0_data;
                r0_nar   <= n0_nar;
                r0_width <= n0_width;
                r0_vec   <= a_vec;
                r1_valid <= n1_valid;
                r1_data  <= n1_data;
                r1_nar   <= n1_nar;
                r1_width <= n0_width;
                r1_vec   <= a_vec;
            end
        end
    end
endmodule

// File: rtl/pam_chk.sv
// Protocol and layout checks for part_meta_adder, attached by bind.
module pam_chk #(
    parameter int NB   = 8,
    parameter int WC_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      op_code,
    input logic [1:0]      policy,
    input logic [WC_W-1:0] a_width,
    input logic            a_vec,
    input logic [WC_W-1:0] b_width,
    input logic            b_vec,
    input logic            out_valid,
    input logic            fault,
    input logic [8*NB-1:0] r0_data,
    input logic [NB-1:0]   r0_nar,
    input logic [WC_W-1:0] r0_width,
    input logic            r0_vec,
    input logic            r1_valid,
    input logic [WC_W-1:0] r1_width
);
    localparam int MAXW = $clog2(NB);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    mismatch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((a_width != b_width) || (a_vec != b_vec))) |=> fault);
    // R10
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault) |-> (r0_data == '0 && r0_nar == '0 && !r1_valid));
    // R7
    widen_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'd3 && op_code < 2'd2 && a_width == b_width &&
         a_vec == b_vec && int'(a_width) < MAXW)
        |=> (!fault && int'(r0_width) == int'($past(a_width)) + 1 && r1_valid == $past(a_vec)));
    // R8
    carry_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'd2 && a_width == b_width && a_vec == b_vec)
        |=> (r1_valid && r1_width == r0_width));
    // R2
    scalar_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !r0_vec) |-> ((r0_data >> (8 << r0_width)) == '0));
endmodule

bind part_meta_adder pam_chk chk_i (.*);

// File: tb/part_meta_adder_tb_top.sv
// Directed bench for part_meta_adder: one task per scenario.
module part_meta_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_code = '0, policy = '0;
    logic        is_signed = 1'b0;
    logic [1:0]  a_width = '0, b_width = '0;
    logic        a_vec = 1'b0, b_vec = 1'b0;
    logic [63:0] a_data = '0, b_data = '0;
    logic [7:0]  a_nar = '0, b_nar = '0;
    logic        out_valid, fault, r0_vec, r1_valid, r1_vec;
    logic [63:0] r0_data, r1_data;
    logic [7:0]  r0_nar, r1_nar;
    logic [1:0]  r0_width, r1_width;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    part_meta_adder dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one request and sample its registered result.
    task automatic issue(input logic [1:0] op, input logic [1:0] pol, input logic sg,
                         input logic [1:0] aw, input logic av, input logic [63:0] ad,
                         input logic [7:0] an, input logic [1:0] bw, input logic bv,
                         input logic [63:0] bd, input logic [7:0] bn);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; policy = pol; is_signed = sg;
        a_width = aw; a_vec = av; a_data = ad; a_nar = an;
        b_width = bw; b_vec = bv; b_data = bd; b_nar = bn;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check("R1", "r1_valid after reset", 64'(r1_valid), 64'd0);
    endtask

    task automatic t_wrap_lanes();
        issue(2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 64'h80FF_0001_7F10_20F0, 8'h00,
              2'd0, 1'b1, 64'h8001_0001_0110_2020, 8'h00);
        check("R1", "out_valid", 64'(out_valid), 64'd1);
        check("R2", "byte lanes wrap", r0_data, 64'h0000_0002_8020_4010);
        check("R4", "byte lanes no fault", 64'(fault), 64'd0);
        issue(2'd0, 2'd0, 1'b0, 2'd1, 1'b1, 64'h80FF_0001_7F10_20F0, 8'h00,
              2'd1, 1'b1, 64'h8001_0001_0110_2020, 8'h00);
        check("R2", "half lanes", r0_data, 64'h0100_0002_8020_4110);
        issue(2'd0, 2'd0, 1'b0, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00,
              2'd3, 1'b0, 64'h1, 8'h00);
        check("R4", "scalar 64-bit wrap", r0_data, 64'h0);
        issue(2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 64'hAAAA_AAAA_AAAA_AA05, 8'hF0,
              2'd0, 1'b0, 64'hBBBB_BBBB_BBBB_BB03, 8'h0E);
        check("R2", "scalar byte upper zero", r0_data, 64'h08);
        check("R2", "scalar byte flags", 64'(r0_nar), 64'h00);
    endtask

    task automatic t_sub();
        issue(2'd1, 2'd0, 1'b0, 2'd0, 1'b1, 64'h0010_0000_0000_0005, 8'h00,
              2'd0, 1'b1, 64'h0001_0000_0000_0007, 8'h00);
        check("R3", "byte lane subtract", r0_data, 64'h000F_0000_0000_00FE);
    endtask

    task automatic t_sat();
        issue(2'd0, 2'd2, 1'b0, 2'd0, 1'b1, 64'hF010, 8'h00, 2'd0, 1'b1, 64'h2020, 8'h00);
        check("R5", "unsigned add clamp", r0_data, 64'hFF30);
        issue(2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 64'h05, 8'h00, 2'd0, 1'b0, 64'h07, 8'h00);
        check("R5", "unsigned sub clamp", r0_data, 64'h00);
        issue(2'd0, 2'd2, 1'b1, 2'd1, 1'b1, 64'h7FFF_8000_0001_FFFF, 8'h00,
              2'd1, 1'b1, 64'h0001_FFFF_0001_FFFF, 8'h00);
        check("R5", "signed half clamp", r0_data, 64'h7FFF_8000_0002_FFFE);
    endtask

    task automatic t_except();
        issue(2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 64'hF010, 8'h00, 2'd0, 1'b1, 64'h2020, 8'h00);
        check("R6", "overflow lane kind", r0_data, 64'h0F30);
        check("R6", "overflow lane flags", 64'(r0_nar), 64'h02);
        check("R6", "no fault", 64'(fault), 64'd0);
    endtask

    task automatic t_widen();
        issue(2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 64'hFF, 8'h00, 2'd0, 1'b0, 64'h02, 8'h00);
        check("R7", "scalar unsigned widen", r0_data, 64'h0101);
        check("R7", "scalar widen width", 64'(r0_width), 64'd1);
        check("R7", "scalar single result", 64'(r1_valid), 64'd0);
        issue(2'd0, 2'd3, 1'b1, 2'd1, 1'b0, 64'h8000, 8'h00, 2'd1, 1'b0, 64'hFFFF, 8'h00);
        check("R7", "scalar signed widen", r0_data, 64'hFFFF_7FFF);
        issue(2'd0, 2'd3, 1'b1, 2'd1, 1'b1, 64'h0004_7FFF_8000_0001, 8'h00,
              2'd1, 1'b1, 64'h0001_0001_FFFF_FFFF, 8'h00);
        check("R7", "vector widen low half", r0_data, 64'hFFFF_7FFF_0000_0000);
        check("R7", "vector widen high half", r1_data, 64'h0000_0005_0000_8000);
        check("R7", "vector widen second valid", 64'(r1_valid), 64'd1);
        check("R7", "vector widen width", 64'(r1_width), 64'd2);
    endtask

    task automatic t_carry();
        issue(2'd2, 2'd2, 1'b0, 2'd2, 1'b1, 64'hFFFF_FFFF_0000_0001, 8'h00,
              2'd2, 1'b1, 64'h0000_0001_0000_0002, 8'h00);
        check("R8", "wrapped sum ignores policy", r0_data, 64'h0000_0000_0000_0003);
        check("R8", "carry per lane", r1_data, 64'h0000_0001_0000_0000);
        check("R8", "carry result valid", 64'(r1_valid), 64'd1);
    endtask

    task automatic t_meta();
        issue(2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 64'h0101_0155_0033_2202, 8'b0001_1110,
              2'd0, 1'b1, 64'h0101_0166_4402_0000, 8'b0001_1011);
        check("R9", "none priority data", r0_data, 64'h0202_0255_0033_0000);
        check("R9", "none priority flags", 64'(r0_nar), 64'h1F);
        issue(2'd0, 2'd0, 1'b0, 2'd1, 1'b1, 64'h1177, 8'b0000_0010,
              2'd1, 1'b1, 64'h0001, 8'h00);
        check("R9", "upper-byte flag kind", r0_data, 64'h0077);
        check("R9", "upper-byte flag lane", 64'(r0_nar), 64'h03);
    endtask

    task automatic t_fault();
        issue(2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 64'h1, 8'h00, 2'd1, 1'b1, 64'h1, 8'h00);
        check("R10", "width mismatch", 64'(fault), 64'd1);
        check("R10", "width mismatch data", r0_data, 64'h0);
        issue(2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 64'h1, 8'h00, 2'd0, 1'b0, 64'h1, 8'h00);
        check("R10", "shape mismatch", 64'(fault), 64'd1);
        issue(2'd0, 2'd3, 1'b0, 2'd3, 1'b0, 64'h1, 8'h00, 2'd3, 1'b0, 64'h1, 8'h00);
        check("R10", "widen at max width", 64'(fault), 64'd1);
        check("R10", "widen at max no second", 64'(r1_valid), 64'd0);
        issue(2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 64'h1, 8'h00, 2'd0, 1'b0, 64'h1, 8'h00);
        check("R10", "illegal opcode", 64'(fault), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "out_valid drops", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap_lanes();
        t_sub();
        t_sat();
        t_except();
        t_widen();
        t_carry();
        t_meta();
        t_fault();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule